// File: doc/BRIEF.md
# 1-Wire Reset and Presence Detector

This block runs the reset step of a 1-Wire master on its own clock-derived time base. A one-cycle start strobe launches a fixed sequence. The open-drain line is first left released for a short pre-idle period. It is then pulled low for the reset width. After that the block releases the line and watches it for the full listen window. Every length is counted in ticks of a fixed period, 10 µs by default. The tick comes from a divider on the system clock, so the waveform never depends on software latency.

During the listen window the pulled-up line level is passed through a synchronizer and sampled once per tick. The samples are classified into one of four outcomes. A responding device must pull the line low within a bounded window and hold it for a bounded time. A line that is already low right after release is a wiring fault. A response that is too short, too long, or still low at the end of the window is a device fault. The outcome is issued as a 2-bit code together with a one-cycle done strobe.

Top module: `ow_reset_presence`

## Requirements
- R1: After reset, `drive_n_o` is 1 (line released) and `done_o` is 0.
- R2: The edge that accepts a start starts the sequence. The line stays released for PRE_TICKS (5) ticks, then `drive_n_o` is 0 for exactly LOW_TICKS (50) ticks. One tick is CLK_PER_TICK clock cycles, and CLK_PER_TICK must be at least 3.
- R3: After release the block listens for LISTEN_TICKS (41) ticks. It then raises `done_o` for exactly one cycle, 96*CLK_PER_TICK+1 cycles after the accepting edge. `result_o` is valid while `done_o` is high, with this encoding: 00 device present, 01 no device, 10 line fault, 11 device fault.
- R4: The line passes through a 2-flop synchronizer and is sampled once at the end of each tick k = 1..41 after release. A low at sample 1 gives 10 (line fault).
- R5: If samples 1..WAIT_TICKS (6) are all high, the result is 01. A later low has no effect on that result.
- R6: A low that starts at a sample from 2 to 6 and turns high again after fewer than MIN_LOW_TICKS (6) low samples gives 11. Exactly 6 low samples are accepted.
- R7: A low that lasts more than MAX_LOW_TICKS (24) samples gives 11. A response with 6 to 24 low samples, where the line stays high from its end through sample 41, gives 00.
- R8: A low at the final sample 41 gives 11. A short low after the response has ended, at any sample other than 41, has no effect.
- R9: A start strobe is ignored while a sequence is running: the running sequence keeps its timing and produces a single done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_n_i | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle request to run a reset sequence |
| line_i | input | 1 | Pulled-up bus level (asynchronous) |
| drive_n_o | output | 1 | 0 = pull the bus low, 1 = release |
| done_o | output | 1 | One-cycle strobe at the end of the sequence |
| result_o | output | 2 | Outcome code, valid with done_o |

## Verification
The sequencer's phase counter sets every timing at the ports. A wrong state there appears either as a wrong drive edge, within one tick of the fault, or as a done strobe off its fixed cycle. The classifier's state and low-sample counter only reach the ports through `result_o`. A fault there is therefore first seen at the done strobe, up to 41 ticks after it occurred. For that reason each window boundary (first sample, last allowed start, shortest and longest response, final sample) gets a line pattern placed exactly on it.

// File: rtl/ow_rp_pkg.sv
package ow_rp_pkg;

    typedef enum logic [1:0] {
        RES_PRESENT      = 2'b00,
        RES_NO_DEVICE    = 2'b01,
        RES_LINE_FAULT   = 2'b10,
        RES_DEVICE_FAULT = 2'b11
    } ow_result_e;

    typedef enum logic [2:0] {
        SEQ_IDLE,
        SEQ_PRE,
        SEQ_LOW,
        SEQ_LISTEN,
        SEQ_REPORT
    } seq_state_e;

    typedef enum logic [1:0] {
        JDG_WAIT,
        JDG_LOW,
        JDG_RELEASED
    } jdg_state_e;

endpackage

// File: rtl/ow_rp_tick.sv
module ow_rp_tick #(
    parameter int DIV = 1000
) (
    input  logic clk_i,
    input  logic rst_n_i,
    input  logic clear_i,
    output logic tick_o
);
    localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } tick_reg_t;

    tick_reg_t r_d, r_q;

    assign tick_o = (r_q.cnt == LAST);

    always_comb begin
        r_d = r_q;
        if (clear_i || tick_o) begin
            r_d.cnt = '0;
        end else begin
            r_d.cnt = r_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    AST_TICK_ISOLATED: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        tick_o |=> !tick_o);  // R2

endmodule

// File: rtl/ow_rp_sync.sv
module ow_rp_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_n_i,
    input  logic async_i,
    output logic sync_o
);
    typedef struct packed {
        logic [STAGES-1:0] chain;
    } sync_reg_t;

    sync_reg_t r_d, r_q;

    assign sync_o = r_q.chain[STAGES-1];

    always_comb begin
        r_d = r_q;
        r_d.chain[0] = async_i;
        for (int i = 1; i < STAGES; i++) begin
            r_d.chain[i] = r_q.chain[i-1];
        end
    end

    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) begin
            r_q <= '1;
        end else begin
            r_q <= r_d;
        end
    end

endmodule

// File: rtl/ow_rp_judge.sv
module ow_rp_judge
    import ow_rp_pkg::*;
#(
    parameter int MIN_LOW = 6,
    parameter int MAX_LOW = 24
) (
    input  logic       clk_i,
    input  logic       rst_n_i,
    input  logic       clear_i,
    input  logic       sample_i,
    input  logic       line_i,
    input  logic       first_i,
    input  logic       wait_end_i,
    input  logic       last_i,
    output ow_result_e verdict_o
);
    localparam int CNT_W = $clog2(MAX_LOW + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MAX_LOW);
    localparam logic [CNT_W-1:0] CNT_MIN = CNT_W'(MIN_LOW);

    typedef struct packed {
        jdg_state_e       st;
        logic [CNT_W-1:0] cnt;
        logic             decided;
        ow_result_e       verdict;
    } jdg_reg_t;

    jdg_reg_t r_d, r_q;

    assign verdict_o = r_q.verdict;

    always_comb begin
        r_d = r_q;
        if (clear_i) begin
            r_d.st      = JDG_WAIT;
            r_d.cnt     = '0;
            r_d.decided = 1'b0;
            r_d.verdict = RES_NO_DEVICE;
        end else if (sample_i && !r_q.decided) begin
            unique case (r_q.st)
                JDG_WAIT: begin
                    if (!line_i) begin
                        if (first_i) begin
                            r_d.decided = 1'b1;
                            r_d.verdict = RES_LINE_FAULT;
                        end else begin
                            r_d.st  = JDG_LOW;
                            r_d.cnt = CNT_W'(1);
                        end
                    end else if (wait_end_i) begin
                        r_d.decided = 1'b1;
                        r_d.verdict = RES_NO_DEVICE;
                    end
                end
                JDG_LOW: begin
                    if (!line_i) begin
                        if (r_q.cnt == CNT_MAX) begin
                            r_d.decided = 1'b1;
                            r_d.verdict = RES_DEVICE_FAULT;
                        end else begin
                            r_d.cnt = r_q.cnt + 1'b1;
                        end
                    end else if (r_q.cnt < CNT_MIN) begin
                        r_d.decided = 1'b1;
                        r_d.verdict = RES_DEVICE_FAULT;
                    end else begin
                        r_d.st = JDG_RELEASED;
                    end
                end
                default: begin
                end
            endcase
            if (last_i && !r_d.decided) begin
                r_d.decided = 1'b1;
                r_d.verdict = (r_d.st == JDG_RELEASED && line_i) ? RES_PRESENT
                                                                  : RES_DEVICE_FAULT;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) begin
            r_q.st      <= JDG_WAIT;
            r_q.cnt     <= '0;
            r_q.decided <= 1'b0;
            r_q.verdict <= RES_NO_DEVICE;
        end else begin
            r_q <= r_d;
        end
    end

    AST_FIRST_LOW_LINE_FAULT: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (sample_i && first_i && !line_i && !clear_i && !r_q.decided)
            |=> (r_q.decided && r_q.verdict == RES_LINE_FAULT));  // R4
    AST_VERDICT_STICKY: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (r_q.decided && !clear_i) |=> (r_q.decided && $stable(r_q.verdict)));  // R8
    AST_COUNT_BOUNDED: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        r_q.cnt <= CNT_MAX);  // R7

endmodule

// File: rtl/ow_reset_presence.sv
module ow_reset_presence
    import ow_rp_pkg::*;
#(
    parameter int CLK_PER_TICK  = 1000,
    parameter int PRE_TICKS     = 5,
    parameter int LOW_TICKS     = 50,
    parameter int LISTEN_TICKS  = 41,
    parameter int WAIT_TICKS    = 6,
    parameter int MIN_LOW_TICKS = 6,
    parameter int MAX_LOW_TICKS = 24,
    parameter int SYNC_STAGES   = 2
) (
    input  logic       clk_i,
    input  logic       rst_n_i,
    input  logic       start_i,
    input  logic       line_i,
    output logic       drive_n_o,
    output logic       done_o,
    output logic [1:0] result_o
);
    localparam int PH_A   = (PRE_TICKS > LOW_TICKS) ? PRE_TICKS : LOW_TICKS;
    localparam int PH_MAX = (PH_A > LISTEN_TICKS) ? PH_A : LISTEN_TICKS;
    localparam int PH_W   = (PH_MAX > 2) ? $clog2(PH_MAX) : 1;
    localparam logic [PH_W-1:0] PRE_LAST    = PH_W'(PRE_TICKS - 1);
    localparam logic [PH_W-1:0] LOW_LAST    = PH_W'(LOW_TICKS - 1);
    localparam logic [PH_W-1:0] LISTEN_LAST = PH_W'(LISTEN_TICKS - 1);
    localparam logic [PH_W-1:0] WAIT_LAST   = PH_W'(WAIT_TICKS - 1);

    typedef struct packed {
        seq_state_e      st;
        logic [PH_W-1:0] phase;
        logic            done;
        ow_result_e      result;
    } seq_reg_t;

    seq_reg_t   r_d, r_q;
    logic       tick;
    logic       clear;
    logic       line_sync;
    logic       sample;
    ow_result_e verdict;

    ow_rp_tick #(.DIV(CLK_PER_TICK)) i_tick (
        .clk_i   (clk_i),
        .rst_n_i (rst_n_i),
        .clear_i (clear),
        .tick_o  (tick)
    );

    ow_rp_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk_i   (clk_i),
        .rst_n_i (rst_n_i),
        .async_i (line_i),
        .sync_o  (line_sync)
    );

    assign sample = (r_q.st == SEQ_LISTEN) && tick;

    ow_rp_judge #(
        .MIN_LOW (MIN_LOW_TICKS),
        .MAX_LOW (MAX_LOW_TICKS)
    ) i_judge (
        .clk_i      (clk_i),
        .rst_n_i    (rst_n_i),
        .clear_i    (clear),
        .sample_i   (sample),
        .line_i     (line_sync),
        .first_i    (r_q.phase == '0),
        .wait_end_i (r_q.phase == WAIT_LAST),
        .last_i     (r_q.phase == LISTEN_LAST),
        .verdict_o  (verdict)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        clear    = 1'b0;
        unique case (r_q.st)
            SEQ_IDLE: begin
                if (start_i) begin
                    r_d.st    = SEQ_PRE;
                    r_d.phase = '0;
                    clear     = 1'b1;
                end
            end
            SEQ_PRE: begin
                if (tick) begin
                    if (r_q.phase == PRE_LAST) begin
                        r_d.st    = SEQ_LOW;
                        r_d.phase = '0;
                    end else begin
                        r_d.phase = r_q.phase + 1'b1;
                    end
                end
            end
            SEQ_LOW: begin
                if (tick) begin
                    if (r_q.phase == LOW_LAST) begin
                        r_d.st    = SEQ_LISTEN;
                        r_d.phase = '0;
                    end else begin
                        r_d.phase = r_q.phase + 1'b1;
                    end
                end
            end
            SEQ_LISTEN: begin
                if (tick) begin
                    if (r_q.phase == LISTEN_LAST) begin
                        r_d.st    = SEQ_REPORT;
                        r_d.phase = '0;
                    end else begin
                        r_d.phase = r_q.phase + 1'b1;
                    end
                end
            end
            SEQ_REPORT: begin
                r_d.st     = SEQ_IDLE;
                r_d.done   = 1'b1;
                r_d.result = verdict;
            end
            default: begin
                r_d.st = SEQ_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) begin
            r_q.st     <= SEQ_IDLE;
            r_q.phase  <= '0;
            r_q.done   <= 1'b0;
            r_q.result <= RES_NO_DEVICE;
        end else begin
            r_q <= r_d;
        end
    end

    assign drive_n_o = (r_q.st != SEQ_LOW);
    assign done_o    = r_q.done;
    assign result_o  = r_q.result;

    AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        done_o |=> !done_o);  // R3
    AST_DRIVE_EDGE_ON_TICK: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        ($rose(drive_n_o) || $fell(drive_n_o)) |-> $past(tick));  // R2
    AST_BUSY_START_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (r_q.st == SEQ_LOW && start_i) |=> (r_q.st == SEQ_LOW || r_q.st == SEQ_LISTEN));  // R9
    AST_DONE_AFTER_REPORT: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        $rose(done_o) |-> $past(r_q.st == SEQ_REPORT));  // R3

endmodule

// File: tb/test_ow_reset_presence.sv
`timescale 1ns/1ps
module test_ow_reset_presence;

    localparam int DIV   = 6;
    localparam int NVEC  = 12;
    localparam int TOTAL = 96 * DIV + 1;

    // {first low sample, first high sample after it, extra low sample, expected, requirement}
    localparam logic [29:0] VEC [NVEC] = '{
        {8'd3,  8'd12, 8'd0,  2'b00, 4'd7},  // R7 normal presence
        {8'd0,  8'd0,  8'd0,  2'b01, 4'd5},  // R5 silent bus
        {8'd1,  8'd10, 8'd0,  2'b10, 4'd4},  // R4 low at first sample
        {8'd3,  8'd7,  8'd0,  2'b11, 4'd6},  // R6 four samples low
        {8'd3,  8'd40, 8'd0,  2'b11, 4'd7},  // R7 never releases in time
        {8'd8,  8'd15, 8'd0,  2'b01, 4'd5},  // R5 response too late, ignored
        {8'd6,  8'd12, 8'd0,  2'b00, 4'd6},  // R6 latest start, minimum width
        {8'd2,  8'd26, 8'd0,  2'b00, 4'd7},  // R7 maximum width
        {8'd2,  8'd27, 8'd0,  2'b11, 4'd7},  // R7 one sample too long
        {8'd3,  8'd12, 8'd41, 2'b11, 4'd8},  // R8 low at final sample
        {8'd3,  8'd8,  8'd0,  2'b11, 4'd6},  // R6 five samples low
        {8'd3,  8'd12, 8'd30, 2'b00, 4'd8}   // R8 stray low ignored
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic       line = 1'b1;
    logic       drive_n;
    logic       done;
    logic [1:0] result;

    int  checks = 0;
    int  errors = 0;
    int  cyc = 0;
    int  rel = 0;
    bit  active = 1'b0;
    bit  drv_prev = 1'b1;
    bit  stuck = 1'b0;
    int  p_s = 0, p_e = 0, p_g = 0;
    int  t_start = 0, t_fall = 0, t_rise = 0, t_done = 0, n_done = 0;
    bit  finished = 1'b0;

    always #2 clk = ~clk;

    ow_reset_presence #(.CLK_PER_TICK(DIV)) i_ow_reset_presence (
        .clk_i     (clk),
        .rst_n_i   (rst_n),
        .start_i   (start),
        .line_i    (line),
        .drive_n_o (drive_n),
        .done_o    (done),
        .result_o  (result)
    );

    always @(posedge clk) cyc <= cyc + 1;

    // slave and bus model, plus edge timestamps
    always @(negedge clk) begin
        int k;
        if (drive_n && !drv_prev) begin
            rel = 0;
            active = 1'b1;
            t_rise = cyc;
        end else if (active) begin
            rel = rel + 1;
        end
        if (!drive_n && drv_prev) t_fall = cyc;
        if (done) begin
            t_done = cyc;
            n_done = n_done + 1;
        end
        drv_prev = drive_n;
        k = rel / DIV + 1;
        if (stuck || !drive_n)
            line = 1'b0;
        else if (active && ((k >= p_s && k < p_e) || k == p_g))
            line = 1'b0;
        else
            line = 1'b1;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic run_seq(input int s, input int e, input int g, input bit stk, input bit busy_start);
        logic [1:0] res;
        p_s = s; p_e = e; p_g = g; stuck = stk;
        active = 1'b0;
        n_done = 0;
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        t_start = cyc;
        for (int i = 0; i < TOTAL + 20; i++) begin
            @(negedge clk);
            if (busy_start && i == 10 * DIV) start = 1'b1;
            else start = 1'b0;
            if (done) begin
                res = result;
                @(negedge clk);
                check(!done, "R3", int'(done), 0);
                break;
            end
        end
        start = 1'b0;
        check(t_fall - t_start == 5 * DIV, "R2", t_fall - t_start, 5 * DIV);
        check(t_rise - t_fall == 50 * DIV, "R2", t_rise - t_fall, 50 * DIV);
        check(t_done - t_start == TOTAL, "R3", t_done - t_start, TOTAL);
        last_res = res;
    endtask

    logic [1:0] last_res;

    initial begin
        #(4 * 150000);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(drive_n == 1'b1, "R1", int'(drive_n), 1);
        check(done == 1'b0, "R1", int'(done), 0);

        for (int v = 0; v < NVEC; v++) begin
            run_seq(int'(VEC[v][29:22]), int'(VEC[v][21:14]), int'(VEC[v][13:6]), 1'b0, 1'b0);
            check(last_res == VEC[v][5:4], $sformatf("R%0d vec%0d", VEC[v][3:0], v),
                  int'(last_res), int'(VEC[v][5:4]));
            repeat (5) @(negedge clk);
        end

        // R4: bus shorted low for the whole sequence
        run_seq(0, 0, 0, 1'b1, 1'b0);
        check(last_res == 2'b10, "R4 stuck", int'(last_res), 2);
        stuck = 1'b0;
        repeat (5) @(negedge clk);

        // R9: second start during the low phase is ignored
        run_seq(3, 12, 0, 1'b0, 1'b1);
        check(last_res == 2'b00, "R9 result", int'(last_res), 0);
        repeat (100 * DIV) @(negedge clk);
        check(n_done == 1, "R9 single done", n_done, 1);
        check(drive_n == 1'b1, "R9 idle", int'(drive_n), 1);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule